// File: doc/BRIEF.md
# Compressed Branch Trace Address Port

This block reports the target address of every taken branch on a narrow trace bus. A core pulses a branch-valid strobe together with the 32-bit target. The block sends that target out one nibble at a time on a 4-bit data bus. A sync line marks the address nibbles, and a trace clock runs at half the core frequency.

To save bus time, each target is compared with the last address that was fully reported. Only the low-order nibbles that can differ are sent. A header nibble goes first and carries a 2-bit size code, so a debug probe can rebuild the full address from its own copy of the previous one. One branch can wait in a holding register while another is being sent. Any further branch is lost, and a sticky flag records the loss until the next reset.

Top module: `btrace_port`

## Requirements
- R1: `tclk_o` toggles on every core clock edge after reset, giving half the core frequency. `tdata_o` and `tsync_o` change only on the edge where `tclk_o` falls, so each value is held for one full trace clock period.
- R2: While no address is pending, `tsync_o` is 1 and `tdata_o` is 4'b0011. This is also the state right after reset.
- R3: A report starts with one header nibble sent with `tsync_o` at 1. Bits 3:2 of the header are 2'b10 and bits 1:0 are the size code.
- R4: The size code is chosen by priority, narrowest first. 2'b00 is used when target bits 31:4 equal the reference, 2'b01 when bits 31:8 are equal, and 2'b10 when bits 31:16 are equal. 2'b11 is used in every other case.
- R5: After the header come 1, 2, 4 or 8 address nibbles for codes 00, 01, 10 and 11. They are sent least significant first: bits 3:0, then 7:4, and so on up to 31:28.
- R6: `tsync_o` is 0 in exactly the trace periods that carry address nibbles.
- R7: The reference address is set to the full target when its last nibble has been sent. After reset no reference exists, so the first report uses code 2'b11.
- R8: A branch that arrives while a report is in progress is held. Its header follows the last nibble of the current report with no idle nibble in between, and it is compressed against the address that was just finished.
- R9: A branch that arrives while the holding register is full, and is not being emptied in that cycle, is dropped. `ovf_o` then goes to 1 and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Branch taken strobe, one cycle per branch |
| br_target_i | input | 32 | Branch target address |
| tclk_o | output | 1 | Trace clock, half the core frequency |
| tsync_o | output | 1 | Low while address nibbles are on the bus |
| tdata_o | output | 4 | Trace nibble: idle code, header or address nibble |
| ovf_o | output | 1 | Sticky flag: a branch was dropped |

## Verification
The hardest case to reach from the ports is a full holding register while a report is still being sent. The bench needs one branch in flight, one waiting, and a third that must be dropped. It waits until its own decoder has seen the header of an 8-nibble report, then sends two branches on back-to-back core cycles. This checks that the held branch follows with no gap, that it is compressed against the report just finished, and that the third branch sets the sticky flag and never appears on the bus.

// File: rtl/btrace_pkg.sv
package btrace_pkg;

   typedef enum logic [1:0] {
      SZ_N1 = 2'b00,
      SZ_N2 = 2'b01,
      SZ_N4 = 2'b10,
      SZ_N8 = 2'b11
   } size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_DATA = 1'b1
   } sh_state_e;

   // number of address nibbles carried by a size code
   function automatic logic [3:0] nib_count(size_e c);
      logic [3:0] n;
      n = 4'd1 << c;
      return n;
   endfunction

endpackage

// File: rtl/btrace_clkdiv.sv
module btrace_clkdiv (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tclk_o,
   output logic tick_o
);
   logic phase_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phase_q <= 1'b0;
      else         phase_q <= ~phase_q;
   end

   // outputs update on the edge where the trace clock falls
   assign tclk_o = phase_q;
   assign tick_o = phase_q;
endmodule

// File: rtl/btrace_hold.sv
module btrace_hold #(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] push_addr_i,
   input  logic              pop_i,
   output logic              full_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              ovf_o
);
   logic              full_q;
   logic [ADDR_W-1:0] addr_q;
   logic              ovf_q;
   logic              accept;
   logic              drop;

   assign accept = push_i && (!full_q || pop_i);
   assign drop   = push_i && full_q && !pop_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         full_q <= 1'b0;
         addr_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (accept) begin
            full_q <= 1'b1;
            addr_q <= push_addr_i;
         end else if (pop_i) begin
            full_q <= 1'b0;
         end
         if (drop) ovf_q <= 1'b1;
      end
   end

   assign full_o = full_q;
   assign addr_o = addr_q;
   assign ovf_o  = ovf_q;
endmodule

// File: rtl/btrace_sizer.sv
module btrace_sizer
   import btrace_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int NIB_W  = 4
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [ADDR_W-1:0] ref_i,
   input  logic              ref_ok_i,
   output size_e             code_o
);
   localparam int LEVELS = 3;

   logic [LEVELS-1:0] match;

   // level g keeps 1<<g low nibbles; everything above must agree
   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      localparam int LO = NIB_W << g;
      assign match[g] = (addr_i[ADDR_W-1:LO] == ref_i[ADDR_W-1:LO]);
   end

   always_comb begin
      if (!ref_ok_i)     code_o = SZ_N8;
      else if (match[0]) code_o = SZ_N1;
      else if (match[1]) code_o = SZ_N2;
      else if (match[2]) code_o = SZ_N4;
      else               code_o = SZ_N8;
   end
endmodule

// File: rtl/btrace_shifter.sv
module btrace_shifter
   import btrace_pkg::*;
#(
   parameter int         ADDR_W   = 32,
   parameter int         NIB_W    = 4,
   parameter logic [3:0] IDLE_NIB = 4'b0011,
   parameter logic [1:0] HDR_TAG  = 2'b10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              have_i,
   input  logic [ADDR_W-1:0] hold_addr_i,
   input  size_e             code_i,
   output logic              pop_o,
   output logic [ADDR_W-1:0] ref_o,
   output logic              ref_ok_o,
   output logic              tsync_o,
   output logic [NIB_W-1:0]  tdata_o
);
   localparam int NUM_NIB = ADDR_W / NIB_W;
   localparam int CNT_W   = $clog2(NUM_NIB + 1);

   sh_state_e         st_q;
   logic [ADDR_W-1:0] sh_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] ref_q;
   logic              ref_ok_q;
   logic [CNT_W-1:0]  left_q;
   logic              tsync_q;
   logic [NIB_W-1:0]  tdata_q;
   logic [3:0]        n_nib;

   assign n_nib = nib_count(code_i);
   assign pop_o = tick_i && (st_q == ST_IDLE) && have_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         sh_q     <= '0;
         cur_q    <= '0;
         ref_q    <= '0;
         ref_ok_q <= 1'b0;
         left_q   <= '0;
         tsync_q  <= 1'b1;
         tdata_q  <= IDLE_NIB;
      end else if (tick_i) begin
         case (st_q)
            ST_IDLE: begin
               tsync_q <= 1'b1;
               if (have_i) begin
                  tdata_q <= {HDR_TAG, code_i};
                  sh_q    <= hold_addr_i;
                  cur_q   <= hold_addr_i;
                  left_q  <= CNT_W'(n_nib);
                  st_q    <= ST_DATA;
               end else begin
                  tdata_q <= IDLE_NIB;
               end
            end
            ST_DATA: begin
               tsync_q <= 1'b0;
               tdata_q <= sh_q[NIB_W-1:0];
               sh_q    <= sh_q >> NIB_W;
               left_q  <= left_q - 1'b1;
               if (left_q == CNT_W'(1)) begin
                  st_q     <= ST_IDLE;
                  ref_q    <= cur_q;
                  ref_ok_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ref_o    = ref_q;
   assign ref_ok_o = ref_ok_q;
   assign tsync_o  = tsync_q;
   assign tdata_o  = tdata_q;
endmodule

// File: rtl/btrace_port.sv
module btrace_port
   import btrace_pkg::*;
#(
   parameter int         ADDR_W   = 32,
   parameter int         NIB_W    = 4,
   parameter logic [3:0] IDLE_NIB = 4'b0011,
   parameter logic [1:0] HDR_TAG  = 2'b10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              br_valid_i,
   input  logic [ADDR_W-1:0] br_target_i,
   output logic              tclk_o,
   output logic              tsync_o,
   output logic [NIB_W-1:0]  tdata_o,
   output logic              ovf_o
);
   if (NIB_W != 4) begin : g_bad_nib
      $error("btrace_port: header layout needs NIB_W == 4");
   end
   if (ADDR_W != 8 * NIB_W) begin : g_bad_addr
      $error("btrace_port: size codes cover exactly eight nibbles");
   end
   if (IDLE_NIB[3:2] == HDR_TAG) begin : g_bad_idle
      $error("btrace_port: idle nibble must not carry the header tag");
   end

   logic              tick;
   logic              pop;
   logic              have;
   logic [ADDR_W-1:0] hold_addr;
   logic [ADDR_W-1:0] ref_addr;
   logic              ref_ok;
   size_e             code;

   btrace_clkdiv u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tclk_o (tclk_o),
      .tick_o (tick)
   );

   btrace_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (br_valid_i),
      .push_addr_i (br_target_i),
      .pop_i       (pop),
      .full_o      (have),
      .addr_o      (hold_addr),
      .ovf_o       (ovf_o)
   );

   btrace_sizer #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_size (
      .addr_i   (hold_addr),
      .ref_i    (ref_addr),
      .ref_ok_i (ref_ok),
      .code_o   (code)
   );

   btrace_shifter #(
      .ADDR_W   (ADDR_W),
      .NIB_W    (NIB_W),
      .IDLE_NIB (IDLE_NIB),
      .HDR_TAG  (HDR_TAG)
   ) u_shift (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .have_i      (have),
      .hold_addr_i (hold_addr),
      .code_i      (code),
      .pop_o       (pop),
      .ref_o       (ref_addr),
      .ref_ok_o    (ref_ok),
      .tsync_o     (tsync_o),
      .tdata_o     (tdata_o)
   );
endmodule

// File: rtl/btrace_chk.sv
module btrace_chk #(
   parameter int         NIB_W    = 4,
   parameter logic [3:0] IDLE_NIB = 4'b0011,
   parameter logic [1:0] HDR_TAG  = 2'b10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             tclk_o,
   input logic             tsync_o,
   input logic [NIB_W-1:0] tdata_o,
   input logic             ovf_o
);
   logic seen_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen_q <= 1'b0;
      else         seen_q <= 1'b1;
   end

   assert_tclk_toggle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen_q |-> (tclk_o != $past(tclk_o)));

   assert_data_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tclk_o |=> ($stable(tdata_o) && $stable(tsync_o)));

   // sync high carries only the idle nibble or a header (R2, R3)
   assert_sync_high_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tsync_o && tdata_o[3:2] != HDR_TAG) |-> (tdata_o == IDLE_NIB));

   assert_hdr_then_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tsync_o && tdata_o[3:2] == HDR_TAG && tclk_o) |=> !tsync_o);

   assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |=> ovf_o);
endmodule

bind btrace_port btrace_chk #(
   .NIB_W    (NIB_W),
   .IDLE_NIB (IDLE_NIB),
   .HDR_TAG  (HDR_TAG)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tclk_o  (tclk_o),
   .tsync_o (tsync_o),
   .tdata_o (tdata_o),
   .ovf_o   (ovf_o)
);

// File: tb/test_btrace_port.sv
module test_btrace_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        br_valid = 1'b0;
   logic [31:0] br_target = '0;
   logic        tclk;
   logic        tsync;
   logic [3:0]  tdata;
   logic        ovf;

   always #4 clk = ~clk;

   btrace_port i_btrace_port (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .br_valid_i  (br_valid),
      .br_target_i (br_target),
      .tclk_o      (tclk),
      .tsync_o     (tsync),
      .tdata_o     (tdata),
      .ovf_o       (ovf)
   );

   // {expected size code, target}
   localparam logic [33:0] VEC [10] = '{
      {2'b11, 32'h1234_5678}, {2'b00, 32'h1234_567C},
      {2'b01, 32'h1234_5610}, {2'b10, 32'h1234_9ABC},
      {2'b11, 32'h8000_0000}, {2'b00, 32'h8000_0000},
      {2'b10, 32'h8000_0F00}, {2'b01, 32'h8000_0FF0},
      {2'b11, 32'hFFFF_FFFF}, {2'b10, 32'hFFFF_0000}
   };

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q [0:63];
   int wr = 0;
   int rd = 0;
   int frames = 0;
   logic [31:0] bref = '0;
   logic        bref_ok = 1'b0;
   logic        in_frame = 1'b0;
   int          need = 0;
   int          got = 0;
   logic [31:0] acc = '0;
   logic [1:0]  hcode = '0;
   logic [1:0]  last_code = '0;
   int          idle_run = 0;
   int          gap_at_hdr = 0;
   logic        prev_tclk = 1'b0;
   logic        mon_on = 1'b0;

   task automatic chk(input logic ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_code(logic [31:0] a, logic [31:0] r, logic ok);
      if (!ok)                   return 2'b11;
      if (a[31:4] == r[31:4])    return 2'b00;
      if (a[31:8] == r[31:8])    return 2'b01;
      if (a[31:16] == r[31:16])  return 2'b10;
      return 2'b11;
   endfunction

   // stream decoder: one sample per trace period, while tclk is high
   always @(negedge clk) begin
      if (mon_on) begin
         if (tclk == prev_tclk) chk(1'b0, "R1 tclk toggle", {31'd0, tclk}, {31'd0, ~prev_tclk});
         prev_tclk = tclk;
         if (tclk) begin
            if (tsync) begin
               if (in_frame) chk(1'b0, "R6 sync high inside address", got, need);
               if (tdata == 4'b0011) begin
                  idle_run++;
               end else if (tdata[3:2] == 2'b10) begin
                  hcode = tdata[1:0];
                  need = 1 << hcode;
                  got = 0;
                  acc = '0;
                  in_frame = 1'b1;
                  gap_at_hdr = idle_run;
                  if (rd == wr) chk(1'b0, "R9 unexpected report", {28'd0, tdata}, 32'd0);
                  else chk(hcode == exp_code(exp_q[rd], bref, bref_ok), "R4 header code",
                           {30'd0, hcode}, {30'd0, exp_code(exp_q[rd], bref, bref_ok)});
               end else begin
                  chk(1'b0, "R2 idle nibble", {28'd0, tdata}, 32'h3);
               end
            end else if (!in_frame) begin
               chk(1'b0, "R6 sync low outside address", {28'd0, tdata}, 32'h3);
            end else begin
               acc = acc | ({28'd0, tdata} << (4 * got));
               got++;
               if (got == need) begin
                  logic [63:0] m;
                  logic [31:0] full;
                  m = (64'd1 << (4 * need)) - 64'd1;
                  full = (bref & ~m[31:0]) | acc;
                  chk(full == exp_q[rd], "R5 rebuilt address", full, exp_q[rd]);
                  bref = exp_q[rd];
                  bref_ok = 1'b1;
                  rd++;
                  frames++;
                  last_code = hcode;
                  in_frame = 1'b0;
                  idle_run = 0;
               end
            end
         end
      end
   end

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   task automatic do_reset();
      mon_on = 1'b0;
      @(negedge clk);
      rst_n = 1'b0;
      br_valid = 1'b0;
      repeat (3) @(negedge clk);
      wr = 0; rd = 0; frames = 0;
      bref_ok = 1'b0; in_frame = 1'b0; idle_run = 0;
      rst_n = 1'b1;
      prev_tclk = 1'b0;
      @(negedge clk);
      prev_tclk = ~tclk;
      mon_on = 1'b1;
   endtask

   task automatic branch(input logic [31:0] a, input logic expect_sent);
      @(negedge clk);
      br_valid = 1'b1;
      br_target = a;
      if (expect_sent) begin
         exp_q[wr[5:0]] = a;
         wr++;
      end
      @(negedge clk);
      br_valid = 1'b0;
   endtask

   task automatic wait_frames(input int n);
      while (frames < n) @(negedge clk);
   endtask

   initial begin
      do_reset();
      // R2, R9: reset state
      chk(tsync == 1'b1, "R2 reset sync", {31'd0, tsync}, 32'd1);
      chk(tdata == 4'b0011, "R2 reset data", {28'd0, tdata}, 32'h3);
      chk(ovf == 1'b0, "R9 reset ovf", {31'd0, ovf}, 32'd0);
      begin
         logic t0;
         t0 = tclk;
         @(negedge clk);
         chk(tclk != t0, "R1 half rate clock", {31'd0, tclk}, {31'd0, ~t0});
      end

      // R3 R4 R5 R7: table of targets and expected size codes
      for (int i = 0; i < 10; i++) begin
         branch(VEC[i][31:0], 1'b1);
         wait_frames(i + 1);
         chk(last_code == VEC[i][33:32], "R4 size code from table",
             {30'd0, last_code}, {30'd0, VEC[i][33:32]});
         repeat (6) @(negedge clk);
         chk(tsync && tdata == 4'b0011, "R2 idle between reports",
             {27'd0, tsync, tdata}, 32'h13);
      end

      // R8 R9: one in flight, one held, one dropped
      branch(32'h0123_4567, 1'b1);
      while (!in_frame) @(negedge clk);
      chk(ovf == 1'b0, "R9 no drop yet", {31'd0, ovf}, 32'd0);
      @(negedge clk);
      br_valid = 1'b1; br_target = 32'h0123_4560;
      exp_q[wr[5:0]] = 32'h0123_4560; wr++;
      @(negedge clk);
      br_target = 32'hDEAD_BEEF;
      @(negedge clk);
      br_valid = 1'b0;
      chk(ovf == 1'b1, "R9 drop sets ovf", {31'd0, ovf}, 32'd1);
      wait_frames(12);
      chk(last_code == 2'b00, "R8 held branch compressed vs previous",
          {30'd0, last_code}, 32'd0);
      chk(gap_at_hdr == 0, "R8 no idle before held header", gap_at_hdr, 32'd0);
      repeat (40) @(negedge clk);
      chk(frames == 12, "R9 dropped branch never sent", frames, 32'd12);
      branch(32'h0123_4561, 1'b1);
      wait_frames(13);
      chk(last_code == 2'b00, "R4 one nibble after drop", {30'd0, last_code}, 32'd0);
      chk(ovf == 1'b1, "R9 ovf sticky", {31'd0, ovf}, 32'd1);

      // R7: reference forgotten by reset
      do_reset();
      chk(ovf == 1'b0, "R9 ovf cleared by reset", {31'd0, ovf}, 32'd0);
      branch(32'h0123_4561, 1'b1);
      wait_frames(1);
      chk(last_code == 2'b11, "R7 first after reset is full", {30'd0, last_code}, 32'h3);
      repeat (10) @(negedge clk);
      summary();
   end
endmodule